// File: doc/BRIEF.md
# Write-Only Serial Current-Code Register

This block is the bus-facing register of a voice-coil current driver. It is an I2C slave that only accepts writes. SCL and SDA are sampled with a fast system clock. Each line passes through a synchronizer and a glitch filter. The block then finds START and STOP conditions and shifts in bytes MSB first. It acknowledges a fixed 7-bit address and the two data bytes that follow it. From those two bytes it builds an 8-bit current code and a power-down flag.

The new code and power-down flag take effect together, and only once the third byte of a frame has been acknowledged. A frame that ends early leaves both values as they were. The drive-enable output tells the analog current loop when it may run. It is cleared by any of these: the enable pin is low, power-down is set, the code is zero, or a thermal or undervoltage fault is active. Pulling the enable pin low also clears the register at once.

Top module: `vcm_code_slave`

## Requirements
- R1: Only the address byte 0x66 (7-bit address 0110011 followed by R/W = 0) is acknowledged. Any other address byte, including a read request, gets no acknowledge, and every byte after it gets none either until the next START.
- R2: START (SDA falls while SCL is high) begins a new frame from its address byte, even in the middle of a frame. STOP (SDA rises while SCL is high) ends the frame. A frame ended either way before its third byte is acknowledged changes no output.
- R3: The acknowledge output `sdaDriveLow` goes high after the eighth SCL falling edge of an accepted byte and returns low after the ninth SCL falling edge. It never changes while SCL is high.
- R4: The second byte carries the power-down flag in bit 7 and code bits 7..2 in bits 5..0. The third byte carries code bits 1..0 in bits 7..6. Second-byte bit 6 and third-byte bits 5..0 are ignored.
- R5: `currentCode` and `powerDown` change only at the end of the acknowledge of the third byte, and both change together.
- R6: A committed frame with the power-down flag at 1 sets `powerDown` and forces `currentCode` to 0. A later frame with the flag at 0 clears `powerDown` and loads its code.
- R7: While `chipEn` is low, the register holds `powerDown` = 0, `currentCode` = 0 and `driveEn` = 0, with no clock edge needed.
- R8: `driveEn` is 1 exactly when `chipEn` is 1, `powerDown` is 0, `currentCode` is non-zero, and both `thermalFault` and `underVoltFault` are 0.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored. An extra SCL pulse inside a bit's low phase does not corrupt the frame.
- R10: Bytes after the third in a frame get no acknowledge and do not change `currentCode` or `powerDown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| chipEn | input | 1 | Active-high enable; low puts the block in standby and resets it asynchronously |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaDriveLow | output | 1 | 1 = pull SDA low (acknowledge); drives an open-drain pad |
| thermalFault | input | 1 | Over-temperature fault, active high |
| underVoltFault | input | 1 | Supply-undervoltage fault, active high |
| currentCode | output | 8 | Committed output-current code (0 = off, 255 = full scale) |
| powerDown | output | 1 | Committed power-down flag |
| driveEn | output | 1 | Enable for the analog current loop |

## Verification
A bus edge reaches the control logic after two synchronizer stages, FILT_LEN filter cycles and one edge-detect register, which with the defaults is about six system clocks. The bench therefore drives SDA ten clocks after each SCL edge and holds each SCL phase for at least twenty clocks. It reads the acknowledge in the middle of the ninth SCL high phase, when `sdaDriveLow` has settled. Code and power-down are committed about six clocks after the ninth falling edge of the third byte, so the bench checks them only after STOP, long after the commit. `driveEn` depends directly on the register outputs and the fault and enable pins, so it is checked a few clocks after each of those changes.

// File: rtl/vcm_slave_pkg.sv
package vcm_slave_pkg;

  // Receiver states of the bus controller.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECV   = 2'd1,
    ST_ACK    = 2'd2,
    ST_IGNORE = 2'd3
  } busState_t;

  // Strobes from the controller to the datapath, one per action.
  typedef struct packed {
    logic shiftIn;   // take one SDA bit into the shift register
    logic clrBits;   // restart the bit counter
    logic clrBytes;  // restart the byte index (new frame)
    logic nextByte;  // advance the byte index
    logic stageHi;   // capture flag and upper code bits from the second byte
    logic stageLo;   // capture lower code bits from the third byte
    logic commit;    // move the staged values to the outputs
  } dpStrobe_t;

endpackage

// File: rtl/vcm_bus_filter.sv
module vcm_bus_filter #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] cleanOut
);

  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    logic [CW-1:0]          runCnt;
    logic                   cleanQ;

    // Synchronizer chain; idle bus level is high.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[gi]};
    end

    // The filtered level follows the input only after FILT_LEN clocks of disagreement in a row.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
        cleanQ <= 1'b1;
      end else if (chain[SYNC_STAGES-1] != cleanQ) begin
        if (runCnt == CW'(FILT_LEN - 1)) begin
          cleanQ <= chain[SYNC_STAGES-1];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end

    assign cleanOut[gi] = cleanQ;
  end

endmodule

// File: rtl/vcm_slave_dp.sv
module vcm_slave_dp
  import vcm_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0110011,
  parameter int         BYTE_W   = 8,
  parameter int         CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaBit,
  input  dpStrobe_t         strobe,
  output logic [3:0]        bitCnt,
  output logic [1:0]        byteIdx,
  output logic              addrHit,
  output logic [CODE_W-1:0] currentCode,
  output logic              powerDown
);

  localparam int HI_W   = BYTE_W - 2;       // code bits carried by the second byte
  localparam int LO_W   = CODE_W - HI_W;    // code bits carried by the third byte
  localparam int FLAG_B = BYTE_W - 1;       // power-down flag position

  logic [BYTE_W-1:0] shiftReg;
  logic              stagePd;
  logic [HI_W-1:0]   stageHiBits;
  logic [LO_W-1:0]   stageLoBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.clrBits) begin
      bitCnt   <= '0;
    end else if (strobe.shiftIn) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                byteIdx <= '0;
    else if (strobe.clrBytes) byteIdx <= '0;
    else if (strobe.nextByte && byteIdx != 2'd3) byteIdx <= byteIdx + 1'b1;
  end

  assign addrHit = (shiftReg == {DEV_ADDR, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagePd     <= 1'b0;
      stageHiBits <= '0;
      stageLoBits <= '0;
    end else begin
      if (strobe.stageHi) begin
        stagePd     <= shiftReg[FLAG_B];
        stageHiBits <= shiftReg[HI_W-1:0];
      end
      if (strobe.stageLo) stageLoBits <= shiftReg[BYTE_W-1 -: LO_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      currentCode <= '0;
      powerDown   <= 1'b0;
    end else if (strobe.commit) begin
      powerDown   <= stagePd;
      currentCode <= stagePd ? '0 : {stageHiBits, stageLoBits};
    end
  end

endmodule

// File: rtl/vcm_slave_ctrl.sv
module vcm_slave_ctrl
  import vcm_slave_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclClean,
  input  logic      sdaClean,
  input  logic [3:0] bitCnt,
  input  logic [1:0] byteIdx,
  input  logic      addrHit,
  output dpStrobe_t strobe,
  output logic      ackDrive
);

  busState_t state, nextState;
  logic sclQ, sdaQ;
  logic sclRise, sclFall, startCond, stopCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
      state <= ST_IDLE;
    end else begin
      sclQ  <= sclClean;
      sdaQ  <= sdaClean;
      state <= nextState;
    end
  end

  assign sclRise   =  sclClean & ~sclQ;
  assign sclFall   = ~sclClean &  sclQ;
  assign startCond =  sclClean &  sclQ & sdaQ & ~sdaClean;
  assign stopCond  =  sclClean &  sclQ & ~sdaQ & sdaClean;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (startCond) begin
      nextState       = ST_RECV;
      strobe.clrBits  = 1'b1;
      strobe.clrBytes = 1'b1;
    end else if (stopCond) begin
      nextState       = ST_IDLE;
      strobe.clrBits  = 1'b1;
      strobe.clrBytes = 1'b1;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (sclRise && bitCnt < 4'd8) strobe.shiftIn = 1'b1;
          if (sclFall && bitCnt == 4'd8) begin
            unique case (byteIdx)
              2'd0: nextState = addrHit ? ST_ACK : ST_IGNORE;
              2'd1: begin
                strobe.stageHi = 1'b1;
                nextState      = ST_ACK;
              end
              2'd2: begin
                strobe.stageLo = 1'b1;
                nextState      = ST_ACK;
              end
              default: nextState = ST_IGNORE;
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            strobe.clrBits  = 1'b1;
            strobe.nextByte = 1'b1;
            strobe.commit   = (byteIdx == 2'd2);
            nextState       = ST_RECV;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  assign ackDrive = (state == ST_ACK);

endmodule

// File: rtl/vcm_code_slave.sv
module vcm_code_slave
  import vcm_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0110011,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         CODE_W      = 8
) (
  input  logic              clk,
  input  logic              chipEn,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic              thermalFault,
  input  logic              underVoltFault,
  output logic [CODE_W-1:0] currentCode,
  output logic              powerDown,
  output logic              driveEn
);

  logic [1:0] cleanLines;
  logic [3:0] bitCnt;
  logic [1:0] byteIdx;
  logic       addrHit;
  dpStrobe_t  strobe;

  vcm_bus_filter #(
    .LINES(2), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)
  ) u_filter (
    .clk(clk), .rstN(chipEn), .rawIn({sdaIn, sclIn}), .cleanOut(cleanLines)
  );

  vcm_slave_ctrl u_ctrl (
    .clk(clk), .rstN(chipEn),
    .sclClean(cleanLines[0]), .sdaClean(cleanLines[1]),
    .bitCnt(bitCnt), .byteIdx(byteIdx), .addrHit(addrHit),
    .strobe(strobe), .ackDrive(sdaDriveLow)
  );

  vcm_slave_dp #(
    .DEV_ADDR(DEV_ADDR), .BYTE_W(8), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(chipEn), .sdaBit(cleanLines[1]), .strobe(strobe),
    .bitCnt(bitCnt), .byteIdx(byteIdx), .addrHit(addrHit),
    .currentCode(currentCode), .powerDown(powerDown)
  );

  assign driveEn = chipEn & ~powerDown & (|currentCode) & ~thermalFault & ~underVoltFault;

endmodule

// File: rtl/vcm_slave_chk.sv
module vcm_slave_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              chipEn,
  input logic              sclIn,
  input logic              sdaDriveLow,
  input logic [CODE_W-1:0] currentCode,
  input logic              powerDown,
  input logic              driveEn,
  input logic              thermalFault,
  input logic              underVoltFault
);

  // R3
  ack_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!chipEn)
    ($rose(sdaDriveLow) || $fell(sdaDriveLow)) |-> !sclIn);

  // R5
  commit_at_ack_end_chk: assert property (@(posedge clk) disable iff (!chipEn)
    (currentCode != $past(currentCode) || powerDown != $past(powerDown)) |-> $fell(sdaDriveLow));

  // R6
  pd_zero_code_chk: assert property (@(posedge clk) disable iff (!chipEn)
    powerDown |-> (currentCode == '0));

  // R7
  standby_clear_chk: assert property (@(posedge clk)
    !chipEn |-> (currentCode == '0 && !powerDown && !driveEn));

  // R8
  drive_gate_chk: assert property (@(posedge clk) disable iff (!chipEn)
    driveEn |-> (!powerDown && currentCode != '0 && !thermalFault && !underVoltFault));

endmodule

bind vcm_code_slave vcm_slave_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/test_vcm_code_slave.sv
module test_vcm_code_slave;

  logic       clk = 1'b0;
  logic       chipEn;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       thermalFault = 1'b0;
  logic       underVoltFault = 1'b0;
  logic       sdaDriveLow;
  logic [7:0] currentCode;
  logic       powerDown;
  logic       driveEn;
  logic       sdaBus;

  int errors = 0;
  int checks = 0;
  logic [7:0] modelCode = 8'h00;
  logic       modelPd   = 1'b0;

  assign sdaBus = sdaM & ~sdaDriveLow;

  always #5 clk = ~clk;

  vcm_code_slave i_vcm_code_slave (
    .clk(clk), .chipEn(chipEn), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .thermalFault(thermalFault),
    .underVoltFault(underVoltFault), .currentCode(currentCode),
    .powerDown(powerDown), .driveEn(driveEn)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expCode(input logic [7:0] b1, input logic [7:0] b2);
    return b1[7] ? 8'h00 : {b1[5:0], b2[7:6]};
  endfunction

  function automatic logic expDrive();
    return chipEn && !modelPd && modelCode != 8'h00 && !thermalFault && !underVoltFault;
  endfunction

  task automatic busStart();
    sdaM = 1'b1; waitClk(10);
    sclM = 1'b1; waitClk(20);
    sdaM = 1'b0; waitClk(20);
    sclM = 1'b0; waitClk(10);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(10);
    sclM = 1'b1; waitClk(20);
    sdaM = 1'b1; waitClk(20);
  endtask

  task automatic sendByte(input logic [7:0] b, input int glitchBit, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      if (i == glitchBit) begin
        waitClk(4); sclM = 1'b1; waitClk(1); sclM = 1'b0; waitClk(5);
      end else begin
        waitClk(10);
      end
      sclM = 1'b1; waitClk(20);
      sclM = 1'b0; waitClk(10);
    end
    sdaM = 1'b1; waitClk(10);
    sclM = 1'b1; waitClk(10);
    ack = sdaDriveLow;
    waitClk(10);
    sclM = 1'b0; waitClk(10);
  endtask

  task automatic writeFrame(input logic [7:0] a, input logic [7:0] b1, input logic [7:0] b2,
                            input int glitchBit, output logic [2:0] acks);
    busStart();
    sendByte(a,  -1,        acks[2]);
    sendByte(b1, glitchBit, acks[1]);
    sendByte(b2, -1,        acks[0]);
    busStop();
    if (a == 8'h66) begin
      modelPd   = b1[7];
      modelCode = expCode(b1, b2);
    end
    waitClk(10);
  endtask

  task automatic checkRegs(input string tag);
    check({tag, " code"}, currentCode, modelCode);
    check({tag, " pd"}, powerDown, modelPd);
    check({tag, " drive"}, driveEn, expDrive());
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [2:0] acks;
    logic       ak;
    void'($urandom(32'd2024));
    chipEn = 1'b1;
    #1 chipEn = 1'b0;
    waitClk(5);
    // R7 state while held in reset
    check("R7 reset code", currentCode, 0);
    check("R7 reset pd", powerDown, 0);
    check("R7 reset drive", driveEn, 0);
    chipEn = 1'b1;
    waitClk(10);
    check("R3 idle ack", sdaDriveLow, 0);

    // R1 R3 R4 R5 R8 basic write
    writeFrame(8'h66, 8'h2A, 8'hC0, -1, acks);
    check("R1 R3 acks", acks, 3'b111);
    check("R4 code 0xAB", currentCode, 8'hAB);
    checkRegs("R8 basic");

    // R4 don't-care bits
    writeFrame(8'h66, 8'h7F, 8'h3F, -1, acks);
    check("R4 ignored bits", currentCode, 8'hFC);

    // R1 wrong address
    writeFrame(8'h68, 8'h01, 8'h00, -1, acks);
    check("R1 wrong addr acks", acks, 3'b000);
    checkRegs("R1 wrong addr");

    // R1 read request
    writeFrame(8'h67, 8'h05, 8'h00, -1, acks);
    check("R1 read acks", acks, 3'b000);
    checkRegs("R1 read");

    // R2 R5 truncated by STOP
    busStart();
    sendByte(8'h66, -1, ak);
    sendByte(8'h01, -1, ak);
    busStop();
    waitClk(10);
    checkRegs("R5 stop cut");

    // R2 repeated START mid-frame, then a full frame
    busStart();
    sendByte(8'h66, -1, ak);
    sendByte(8'h3F, -1, ak);
    sclM = 1'b0; waitClk(5);
    writeFrame(8'h66, 8'h05, 8'h40, -1, acks);
    check("R2 restart acks", acks, 3'b111);
    check("R2 restart code", currentCode, 8'h15);

    // R10 extra byte
    busStart();
    sendByte(8'h66, -1, ak);
    sendByte(8'h20, -1, ak);
    sendByte(8'h80, -1, ak);
    sendByte(8'hFF, -1, ak);
    check("R10 extra nack", ak, 0);
    busStop();
    modelCode = 8'h82; modelPd = 1'b0;
    waitClk(10);
    checkRegs("R10 extra");

    // R6 power-down then wake
    writeFrame(8'h66, 8'hBF, 8'hC0, -1, acks);
    check("R6 pd set", powerDown, 1);
    check("R6 pd code", currentCode, 0);
    check("R6 pd drive", driveEn, 0);
    writeFrame(8'h66, 8'h10, 8'h80, -1, acks);
    check("R6 wake code", currentCode, 8'h42);
    check("R6 wake pd", powerDown, 0);

    // R8 fault gating
    thermalFault = 1'b1; waitClk(3);
    check("R8 thermal", driveEn, 0);
    thermalFault = 1'b0; underVoltFault = 1'b1; waitClk(3);
    check("R8 undervolt", driveEn, 0);
    underVoltFault = 1'b0; waitClk(3);
    check("R8 clear", driveEn, 1);

    // R8 code zero
    writeFrame(8'h66, 8'h00, 8'h00, -1, acks);
    check("R8 code0 drive", driveEn, 0);

    // R9 glitch on SCL during second byte
    writeFrame(8'h66, 8'h19, 8'h40, 3, acks);
    check("R9 glitch acks", acks, 3'b111);
    check("R9 glitch code", currentCode, 8'h65);

    // R7 asynchronous reset in operation
    #3 chipEn = 1'b0;
    #1;
    check("R7 async code", currentCode, 0);
    check("R7 async drive", driveEn, 0);
    modelCode = 8'h00; modelPd = 1'b0;
    waitClk(4);
    chipEn = 1'b1;
    waitClk(10);
    checkRegs("R7 after");

    // Random frames: R1 R4 R5 R6
    for (int n = 0; n < 24; n++) begin
      logic [7:0] a, b1, b2;
      a  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h66;
      b1 = 8'($urandom);
      b2 = 8'($urandom);
      writeFrame(a, b1, b2, -1, acks);
      check("R1 random acks", acks, (a == 8'h66) ? 3'b111 : 3'b000);
      checkRegs("R4 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule